// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel words into an asynchronous serial bit stream. A one-word holding register sits in front of the frame shifter, so software can queue the next word while the current one is still on the line. Two status flags tell software where the pipeline stands. The empty flag shows that the holding register can take a word. The done flag shows that the line has gone quiet with nothing queued. An interrupt output follows the done flag when software enables it.

A control write sets four things at once: the transmitter enable, a line-break request, the interrupt enable and the word length (8 or 9 data bits). When the transmitter is first enabled, it sends one all-high idle frame before any data. A break request holds the line low for a full frame and then returns it high. The request bit clears itself. The bit rate comes from a single-cycle `baud_tick` enable, and every bit lasts `OVS` ticks.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `tx_done` is 1, `break_busy` is 0 and `irq` is 0.
- R2: A data frame is one start bit (0), then the data bits LSB first, then one stop bit (1). There are 8 data bits when the word-length control bit is 0 and 9 when it is 1. Each bit lasts 16 cycles in which `baud_tick` is high.
- R3: A data write while enabled, with no frame on the line and nothing pending, starts the frame at once, and `tx_empty` stays 1.
- R4: A data write while a frame is on the line or pending goes to the holding register and drops `tx_empty` to 0. The held word moves to the shifter when the current frame ends, and `tx_empty` returns to 1 at that point.
- R5: `tx_done` rises only when a frame ends while `tx_empty` is 1. If a word is still held at the end of a frame, `tx_done` stays 0.
- R6: A status read followed by a data write clears `tx_done`. A data write without a preceding status read leaves `tx_done` unchanged. A `tc_clear` pulse clears `tx_done`.
- R7: `irq` is 1 exactly when the interrupt-enable control bit and `tx_done` are both 1.
- R8: When the enable control bit goes from 0 to 1, the line stays high for one full frame (10 or 11 bit times) before the first data frame.
- R9: A break request is served after the current frame. The line is held low for the start bit plus all data bits (144 or 160 cycles at one tick per cycle), then driven high for one bit time. `break_busy` clears by itself during that high slot.
- R10: A break request withdrawn by a control write before the break starts sends no break.
- R11: When several things are pending at the end of a frame, they are served in this order: the idle preamble, then the break, then the held data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Bit-rate enable; one bit lasts OVS ticks |
| data_we | input | 1 | Data write strobe |
| data_in | input | DW (9) | Word to send; the top bit is used only in 9-bit mode |
| ctrl_we | input | 1 | Control write strobe; loads all four control bits |
| ctrl_enable | input | 1 | Transmitter enable |
| ctrl_break | input | 1 | Break request |
| ctrl_tcie | input | 1 | Interrupt enable for the done flag |
| ctrl_nine | input | 1 | Word length: 1 selects 9 data bits |
| status_rd | input | 1 | Status read strobe (arms the done-flag clear) |
| tc_clear | input | 1 | Clears the done flag directly |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | Transmission complete |
| break_busy | output | 1 | Break request still pending or in progress |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a frame ending while several things are pending at the same time: the done flag must stay low, the break must come before the held word, and the break bit must clear only in the trailing high slot. The stimulus writes one word so that it starts directly, writes a second word at once so that it lands in the holding register, and sets the break request, all within the first bit time of the first frame. The bench then measures the low run of the break to the cycle and decodes the held word after it. A full sweep of all 8-bit values and a spread of 9-bit values covers the frame format.

// File: rtl/dst_pkg.sv
package dst_pkg;
    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_IDLE  = 2'd1,
        FK_BREAK = 2'd2,
        FK_DATA  = 2'd3
    } frame_kind_e;
endpackage

// File: rtl/dst_bit_timer.sv
module dst_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] CMAX = CW'(OVS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        bit_done = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            if (cnt_q == CMAX) begin
                cnt_d    = '0;
                bit_done = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/dst_frame_engine.sv
module dst_frame_engine #(
    parameter int OVS = 16,
    parameter int FW  = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          nine,
    output logic          line,
    output logic          busy,
    output logic          frame_end,
    output logic          last_bit
);
    localparam int IW = $clog2(FW);

    typedef struct packed {
        logic [FW-1:0] shift;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
        logic          busy;
        logic          fend;
    } eng_t;

    eng_t st_d, st_q;
    logic bit_done;

    dst_bit_timer #(.OVS(OVS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.busy),
        .restart  (load),
        .tick     (tick),
        .bit_done (bit_done)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fend = 1'b0;
        if (load) begin
            st_d.shift = frame;
            st_d.idx   = '0;
            st_d.last  = nine ? IW'(FW - 1) : IW'(FW - 2);
            st_d.busy  = 1'b1;
        end else if (bit_done) begin
            if (st_q.idx == st_q.last) begin
                st_d.busy  = 1'b0;
                st_d.fend  = 1'b1;
                st_d.shift = '1;
            end else begin
                st_d.shift = {1'b1, st_q.shift[FW-1:1]};
                st_d.idx   = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.shift <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line      = st_q.shift[0];
    assign busy      = st_q.busy;
    assign frame_end = st_q.fend;
    assign last_bit  = st_q.busy && (st_q.idx == st_q.last);

    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(line));
    assert_end_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fend |-> !st_q.busy);
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
    import dst_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          data_we,
    input  logic [DW-1:0] data_in,
    input  logic          ctrl_we,
    input  logic          ctrl_enable,
    input  logic          ctrl_break,
    input  logic          ctrl_tcie,
    input  logic          ctrl_nine,
    input  logic          status_rd,
    input  logic          tc_clear,
    output logic          txd,
    output logic          tx_empty,
    output logic          tx_done,
    output logic          break_busy,
    output logic          irq
);
    localparam int FW = DW + 2;

    typedef struct packed {
        logic          en;
        logic          tcie;
        logic          nine;
        logic          brk;
        logic          pre;
        logic          txe;
        logic          tc;
        logic          rd_seen;
        logic          last_seen;
        logic [DW-1:0] hold;
        frame_kind_e   kind;
    } ctl_t;

    ctl_t st_d, st_q;

    logic          start;
    logic [FW-1:0] start_frame;
    logic          eng_busy, eng_end, eng_last, eng_line;

    function automatic logic [FW-1:0] mk_data(input logic [DW-1:0] d, input logic nine);
        return nine ? {1'b1, d, 1'b0} : {2'b11, d[DW-2:0], 1'b0};
    endfunction

    function automatic logic [FW-1:0] mk_break(input logic nine);
        return nine ? {1'b1, {(FW-1){1'b0}}} : {2'b11, {(FW-2){1'b0}}};
    endfunction

    always_comb begin
        st_d        = st_q;
        start       = 1'b0;
        start_frame = '1;

        // next frame when the shifter is free: preamble, break, held word
        if (st_q.en && !eng_busy) begin
            if (st_q.pre) begin
                start        = 1'b1;
                start_frame  = '1;
                st_d.pre     = 1'b0;
                st_d.kind    = FK_IDLE;
            end else if (st_q.brk) begin
                start        = 1'b1;
                start_frame  = mk_break(st_q.nine);
                st_d.kind    = FK_BREAK;
            end else if (!st_q.txe) begin
                start        = 1'b1;
                start_frame  = mk_data(st_q.hold, st_q.nine);
                st_d.txe     = 1'b1;
                st_d.kind    = FK_DATA;
            end
        end

        if (data_we) begin
            if (!start && st_q.en && !eng_busy && !st_q.pre && !st_q.brk && st_q.txe) begin
                start       = 1'b1;
                start_frame = mk_data(data_in, st_q.nine);
                st_d.kind   = FK_DATA;
            end else begin
                st_d.hold = data_in;
                st_d.txe  = 1'b0;
            end
            if (st_q.rd_seen) st_d.tc = 1'b0;
            st_d.rd_seen = 1'b0;
        end
        if (status_rd) st_d.rd_seen = 1'b1;
        if (tc_clear)  st_d.tc      = 1'b0;
        if (eng_end && st_q.txe) st_d.tc = 1'b1;

        // self-clear of the break request on entry to its trailing high slot
        st_d.last_seen = eng_last;
        if (st_q.kind == FK_BREAK && eng_last && !st_q.last_seen) st_d.brk = 1'b0;

        if (ctrl_we) begin
            st_d.en   = ctrl_enable;
            st_d.tcie = ctrl_tcie;
            st_d.nine = ctrl_nine;
            st_d.brk  = ctrl_break;
            if (!ctrl_enable)               st_d.pre = 1'b0;
            else if (!st_q.en)              st_d.pre = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.txe  <= 1'b1;
            st_q.tc   <= 1'b1;
            st_q.kind <= FK_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    dst_frame_engine #(.OVS(OVS), .FW(FW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .load      (start),
        .frame     (start_frame),
        .nine      (st_q.nine),
        .line      (eng_line),
        .busy      (eng_busy),
        .frame_end (eng_end),
        .last_bit  (eng_last)
    );

    assign txd        = eng_line;
    assign tx_empty   = st_q.txe;
    assign tx_done    = st_q.tc;
    assign break_busy = st_q.brk;
    assign irq        = st_q.tcie & st_q.tc;

    assert_txe_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.txe) |-> $rose(eng_busy));
    assert_tc_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tc) |-> ($past(eng_end) && $past(st_q.txe)));
    assert_brk_selfclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.brk) && !$past(ctrl_we)) |-> ($past(eng_last) && $past(st_q.kind) == FK_BREAK));
    assert_direct_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eng_busy) && $past(data_we) && $past(st_q.txe) && !$past(st_q.pre) && !$past(st_q.brk))
        |-> st_q.txe);
endmodule

// File: tb/dbuf_serial_tx_test.sv
module dbuf_serial_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b1;
    logic data_we = 1'b0;
    logic [8:0] data_in = '0;
    logic ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_break = 1'b0, ctrl_tcie = 1'b0, ctrl_nine = 1'b0;
    logic status_rd = 1'b0, tc_clear = 1'b0;
    logic txd, tx_empty, tx_done, break_busy, irq;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int ph = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dbuf_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .data_we(data_we), .data_in(data_in),
        .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable), .ctrl_break(ctrl_break),
        .ctrl_tcie(ctrl_tcie), .ctrl_nine(ctrl_nine),
        .status_rd(status_rd), .tc_clear(tc_clear),
        .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done),
        .break_busy(break_busy), .irq(irq)
    );

    always @(negedge clk) begin
        ph        <= (ph >= tick_div - 1) ? 0 : ph + 1;
        baud_tick <= (ph == 0);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input bit en, input bit brk, input bit ie, input bit nine);
        ctrl_we = 1'b1; ctrl_enable = en; ctrl_break = brk; ctrl_tcie = ie; ctrl_nine = nine;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [8:0] d);
        data_we = 1'b1; data_in = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic rd_stat();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic clr_tc();
        tc_clear = 1'b1;
        @(negedge clk);
        tc_clear = 1'b0;
    endtask

    task automatic wait_low(output bit found);
        found = 1'b0;
        for (int i = 0; i < 4000 * tick_div; i++) begin
            if (txd == 1'b0) begin
                found = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // decode one frame: sample in the middle of every bit
    task automatic capture(input int nbits, input logic [8:0] exp, input string req);
        bit found;
        logic [8:0] w;
        logic st, sp;
        int bt;
        bt = 16 * tick_div;
        w  = '0;
        wait_low(found);
        chk(found, {req, " start edge seen"}, found, 1);
        step(bt / 2);
        st = txd;
        for (int i = 0; i < nbits; i++) begin
            step(bt);
            w[i] = txd;
        end
        step(bt);
        sp = txd;
        chk(st == 1'b0, {req, " start bit"}, st, 0);
        chk(w == exp, {req, " data bits"}, w, exp);
        chk(sp == 1'b1, {req, " stop bit"}, sp, 1);
    endtask

    task automatic measure_low(output int n, output bit brk_seen);
        bit found;
        n = 0;
        wait_low(found);
        brk_seen = break_busy;
        while (txd == 1'b0 && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        bit b;
        int lows;
        logic [8:0] v;

        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(tx_done == 1'b1, "R1 tx_done", tx_done, 1);
        chk(break_busy == 1'b0, "R1 break_busy", break_busy, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R6 direct clear strobe
        clr_tc();
        chk(tx_done == 1'b0, "R6 tc_clear", tx_done, 0);

        // R8 preamble on enable, word queued behind it (R4)
        wr_ctrl(1, 0, 1, 0);
        wr_data(9'h05A);
        chk(tx_empty == 1'b0, "R4 held during preamble", tx_empty, 0);
        n = 0;
        while (txd == 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n >= 155 && n <= 165, "R8 idle frame length", n, 161);
        chk(tx_empty == 1'b1, "R4 empty after move", tx_empty, 1);
        chk(tx_done == 1'b0, "R5 not set after preamble with held word", tx_done, 0);
        capture(8, 9'h05A, "R2 first word");
        step(20);
        chk(tx_done == 1'b1, "R5 set after last frame", tx_done, 1);
        chk(irq == 1'b1, "R7 irq with tcie", irq, 1);

        // R2/R3/R6 sweep of all 8-bit words
        for (int k = 0; k < 256; k++) begin
            rd_stat();
            wr_data(9'(k));
            chk(tx_empty == 1'b1, "R3 empty kept on direct load", tx_empty, 1);
            chk(tx_done == 1'b0, "R6 read then write clears", tx_done, 0);
            capture(8, 9'(k), "R2 8-bit sweep");
            step(20);
            chk(tx_done == 1'b1, "R5 done after frame", tx_done, 1);
        end

        // R2 9-bit words
        wr_ctrl(1, 0, 1, 1);
        for (int k = 0; k < 40; k++) begin
            v = 9'((k * 77 + 3) % 512);
            wr_data(v);
            capture(9, v, "R2 9-bit");
            step(20);
        end

        // R2 slow tick
        wr_ctrl(1, 0, 1, 0);
        tick_div = 3;
        step(4);
        wr_data(9'h0C3);
        capture(8, 9'h0C3, "R2 tick every 3rd cycle");
        step(60);
        tick_div = 1;
        step(4);

        // R4/R5 back-to-back with gating
        rd_stat();
        wr_data(9'h011);
        wr_data(9'h0EE);
        chk(tx_empty == 1'b0, "R4 second write held", tx_empty, 0);
        capture(8, 9'h011, "R4 first of pair");
        capture(8, 9'h0EE, "R4 second of pair");
        chk(tx_done == 1'b0, "R5 gated by held word", tx_done, 0);
        step(20);
        chk(tx_done == 1'b1, "R5 set after pair", tx_done, 1);

        // R6 write without read keeps flag; R7 interrupt enable
        wr_data(9'h07E);
        chk(tx_done == 1'b1, "R6 write without read", tx_done, 1);
        capture(8, 9'h07E, "R6 frame");
        step(20);
        wr_ctrl(1, 0, 0, 0);
        chk(irq == 1'b0, "R7 irq masked", irq, 0);
        chk(tx_done == 1'b1, "R7 flag still set", tx_done, 1);
        wr_ctrl(1, 0, 1, 0);
        chk(irq == 1'b1, "R7 irq unmasked", irq, 1);
        clr_tc();
        chk(irq == 1'b0, "R7 irq follows flag", irq, 0);

        // R9 break after current frame, 8-bit
        wr_data(9'h0A5);
        wr_ctrl(1, 1, 0, 0);
        capture(8, 9'h0A5, "R9 frame before break");
        measure_low(n, b);
        chk(n == 144, "R9 break length 8-bit", n, 144);
        chk(b == 1'b1, "R9 break_busy during break", b, 1);
        step(3);
        chk(break_busy == 1'b0, "R9 self-clear", break_busy, 0);
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            if (txd == 1'b0) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R9 trailing high slot", lows, 0);
        step(10);

        // R9 9-bit break from idle
        wr_ctrl(1, 1, 0, 1);
        measure_low(n, b);
        chk(n == 160, "R9 break length 9-bit", n, 160);
        step(20);
        chk(break_busy == 1'b0, "R9 self-clear 9-bit", break_busy, 0);
        wr_ctrl(1, 0, 0, 0);

        // R11 ordering: break before held word
        wr_data(9'h033);
        wr_data(9'h0CC);
        wr_ctrl(1, 1, 0, 0);
        capture(8, 9'h033, "R11 first");
        measure_low(n, b);
        chk(n == 144, "R11 break comes next", n, 144);
        capture(8, 9'h0CC, "R11 held word last");
        step(20);

        // R10 withdrawn break
        wr_data(9'h066);
        wr_ctrl(1, 1, 0, 0);
        wr_ctrl(1, 0, 0, 0);
        capture(8, 9'h066, "R10 frame");
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            if (txd == 1'b0) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R10 no break sent", lows, 0);
        chk(break_busy == 1'b0, "R10 request gone", break_busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule